// File: doc/BRIEF.md
# Bit-Plane Coding Pass and Operation Classifier

This block sorts every bit of one bit-plane of a code-block into a coding pass, with all bits handled in parallel. It does not replay a serial stripe scan. Upstream logic supplies four per-coefficient maps:

- significance from higher planes (`rho`);
- becomes-significant-in-this-plane (`tau`);
- preferred-neighbourhood (`delta`);
- the current bit values.

It also supplies the index of each coefficient's highest nonzero plane and the current plane number.

On an accepted start the block registers, for each bit:

- its pass: significance propagation, magnitude refinement or cleanup;
- the coding operations that bit needs: zero coding, run-length coding, magnitude refinement and sign coding;
- a flag that says whether a refinement bit has been refined before;
- the effective significance seen by neighbours.

Run-length coding uses the standard four-row stripe columns. The run decision and the split of a column into run-coded and zero-coded bits are made from the maps alone.

After each accepted start, four one-cycle phase strobes follow in a fixed order: refinement, run-length, zero coding, sign coding. Downstream coding engines use these strobes to consume the held flags group by group. Computing the context numbers and the arithmetic coder are outside this block.

Top module: `bitplane_pass_sorter`

## Requirements
- R1: Each bit is placed in exactly one pass. The magnitude refinement pass holds the bits with rho=1. The significance propagation pass holds the bits with rho=0 and delta=1. The cleanup pass holds the bits with rho=0 and delta=0.
- R2: Every significance propagation bit is flagged for zero coding, and also for sign coding when its bit value is 1.
- R3: Every refinement bit is flagged for magnitude refinement and for no other operation. Its again flag is 1 exactly when the first nonzero plane index minus the current plane is greater than 1.
- R4: A cleanup bit outside a run column is flagged for zero coding, and also for sign coding when its bit value is 1.
- R5: A stripe column (rows 4k to 4k+3 of one column) is a run column when two conditions hold.
  - All four of its bits are cleanup bits.
  - No cell of its surrounding ring (columns x-1 to x+1, rows 4k-1 to 4k+4) is significant. A ring cell counts as significant when rho XOR tau is 1. A ring cell that comes earlier in scan order also counts when it is a cleanup bit equal to 1; the earlier cells are row 4k-1 and left-column rows 4k to 4k+3. Cells outside the block count as insignificant.
- R6: In a run column, the rows up to and including the first row whose bit is 1 are flagged for run-length coding and not zero coding. The rows after it are flagged for zero coding. Any bit equal to 1 is also flagged for sign coding.
- R7: The significance output of each bit equals rho XOR tau.
- R8: One cycle after an accepted start, phase_o is 0001 (refinement). In the following cycles it is 0010 (run-length), then 0100 (zero coding), then 1000 (sign coding), then 0000.
- R9: A start while phase_o is nonzero is ignored. All classification outputs hold the values captured at the last accepted start.
- R10: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| start_i | input | 1 | Capture request, accepted when phase_o is zero |
| plane_i | input | PLANE_W | Current bit-plane index p |
| rho_i | input | COLS*ROWS | Significance from higher planes, bit y*COLS+x |
| tau_i | input | COLS*ROWS | Becomes significant in this plane's first pass |
| delta_i | input | COLS*ROWS | Preferred-neighbourhood map |
| bit_i | input | COLS*ROWS | Current bit values |
| first_nz_i | input | COLS*ROWS*PLANE_W | Highest nonzero plane per coefficient, field i at [i*PLANE_W +: PLANE_W] |
| spp_o | output | COLS*ROWS | Significance propagation pass member |
| mrp_o | output | COLS*ROWS | Magnitude refinement pass member |
| cup_o | output | COLS*ROWS | Cleanup pass member |
| zc_o | output | COLS*ROWS | Zero coding flag |
| rlc_o | output | COLS*ROWS | Run-length coding flag |
| mrc_o | output | COLS*ROWS | Magnitude refinement flag |
| sc_o | output | COLS*ROWS | Sign coding flag |
| again_o | output | COLS*ROWS | Refinement bit was refined before |
| sig_o | output | COLS*ROWS | Effective significance rho XOR tau |
| phase_o | output | 4 | One-hot phase strobe, bit 0 first |

## Verification
The bench builds the block with a 4-column by 8-row block and a 3-bit plane index. At this size there are two full stripes and every ring case of R5 occurs: the top and bottom block edges, the boundary between the two stripes, and the left and right columns.

Coefficients are 4-bit magnitudes. They come from directed images and many random images of varying density. Each image is taken through all four planes by a serial stripe-scan model that keeps significance, visited and refined states. That model produces the rho, tau and delta inputs and the expected pass and operation maps, so the parallel decisions, including run starts and run breaks, are compared with sequential behaviour over a wide range of neighbourhoods.

// File: rtl/bitplane_sort_pkg.sv
package bitplane_sort_pkg;
  localparam int NUM_PHASES = 4;
  localparam int STRIPE_H   = 4;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_MRC  = 3'd1,
    PH_RLC  = 3'd2,
    PH_ZC   = 3'd3,
    PH_SC   = 3'd4
  } phase_e;
endpackage

// File: rtl/bitplane_pass_split.sv
module bitplane_pass_split #(
  parameter int NBITS   = 32,
  parameter int PLANE_W = 3
) (
  input  logic [NBITS-1:0]         rho_i,
  input  logic [NBITS-1:0]         tau_i,
  input  logic [NBITS-1:0]         delta_i,
  input  logic [NBITS*PLANE_W-1:0] first_nz_i,
  input  logic [PLANE_W-1:0]       plane_i,
  output logic [NBITS-1:0]         spp_o,
  output logic [NBITS-1:0]         mrp_o,
  output logic [NBITS-1:0]         cup_o,
  output logic [NBITS-1:0]         sig_o,
  output logic [NBITS-1:0]         again_o
);
  localparam int CW = PLANE_W + 1;

  logic [CW-1:0] plane_plus1;
  assign plane_plus1 = {1'b0, plane_i} + CW'(1);

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    logic [CW-1:0] first_ext;
    assign first_ext  = {1'b0, first_nz_i[i*PLANE_W +: PLANE_W]};
    assign mrp_o[i]   = rho_i[i];
    assign spp_o[i]   = ~rho_i[i] & delta_i[i];
    assign cup_o[i]   = ~rho_i[i] & ~delta_i[i];
    assign sig_o[i]   = rho_i[i] ^ tau_i[i];
    assign again_o[i] = rho_i[i] & (first_ext > plane_plus1);
  end
endmodule

// File: rtl/bitplane_run_finder.sv
module bitplane_run_finder
  import bitplane_sort_pkg::*;
#(
  parameter int COLS = 4,
  parameter int ROWS = 8
) (
  input  logic [COLS*ROWS-1:0] cup_i,
  input  logic [COLS*ROWS-1:0] bit_i,
  input  logic [COLS*ROWS-1:0] sig_i,
  output logic [COLS*ROWS-1:0] rlc_o
);
  localparam int STRIPES = ROWS / STRIPE_H;
  localparam int RING_H  = STRIPE_H + 2;
  localparam int RING_N  = 3 * RING_H;

  for (genvar k = 0; k < STRIPES; k++) begin : g_stripe
    for (genvar x = 0; x < COLS; x++) begin : g_col
      logic [RING_N-1:0]   hit;
      logic [STRIPE_H-1:0] col_cup;
      logic [STRIPE_H-1:0] col_bit;
      logic                run_col;

      for (genvar dx = 0; dx < 3; dx++) begin : g_rx
        for (genvar dy = 0; dy < RING_H; dy++) begin : g_ry
          localparam int CX    = x + dx - 1;
          localparam int CY    = k*STRIPE_H + dy - 1;
          localparam bit INNER = (dx == 1) && (dy >= 1) && (dy <= STRIPE_H);
          localparam bit EARLY = (dy == 0) || ((dx == 0) && (dy <= STRIPE_H));
          if (!INNER && CX >= 0 && CX < COLS && CY >= 0 && CY < ROWS) begin : g_in
            if (EARLY) begin : g_early
              assign hit[dx*RING_H+dy] = sig_i[CY*COLS+CX] |
                                         (cup_i[CY*COLS+CX] & bit_i[CY*COLS+CX]);
            end else begin : g_late
              assign hit[dx*RING_H+dy] = sig_i[CY*COLS+CX];
            end
          end else begin : g_out
            assign hit[dx*RING_H+dy] = 1'b0;
          end
        end
      end

      for (genvar r = 0; r < STRIPE_H; r++) begin : g_row
        localparam int IDX = (k*STRIPE_H + r)*COLS + x;
        localparam logic [STRIPE_H-1:0] ABOVE = STRIPE_H'((1 << r) - 1);
        assign col_cup[r] = cup_i[IDX];
        assign col_bit[r] = bit_i[IDX];
        assign rlc_o[IDX] = run_col & ~|(col_bit & ABOVE);
      end

      assign run_col = (&col_cup) & ~|hit;
    end
  end
endmodule

// File: rtl/bitplane_phase_seq.sv
module bitplane_phase_seq
  import bitplane_sort_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  output logic                  accept_o,
  output logic [NUM_PHASES-1:0] phase_o
);
  phase_e state_q, state_d;

  assign accept_o = start_i & (state_q == PH_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      PH_IDLE: if (start_i) state_d = PH_MRC;
      PH_MRC:  state_d = PH_RLC;
      PH_RLC:  state_d = PH_ZC;
      PH_ZC:   state_d = PH_SC;
      PH_SC:   state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    phase_o = '0;
    case (state_q)
      PH_MRC:  phase_o = 4'b0001;
      PH_RLC:  phase_o = 4'b0010;
      PH_ZC:   phase_o = 4'b0100;
      PH_SC:   phase_o = 4'b1000;
      default: phase_o = '0;
    endcase
  end

  // R8
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phase_o));
  // R8
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && phase_o == 4'b0000) |=> phase_o == 4'b0001);
  // R8
  mrc_then_rlc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o == 4'b0001 |=> phase_o == 4'b0010);
  // R8
  rlc_then_zc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o == 4'b0010 |=> phase_o == 4'b0100);
  // R8
  zc_then_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o == 4'b0100 |=> phase_o == 4'b1000);
  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o != 4'b0000 |=> !phase_o[0]);
endmodule

// File: rtl/bitplane_pass_sorter.sv
module bitplane_pass_sorter
  import bitplane_sort_pkg::*;
#(
  parameter int COLS    = 4,
  parameter int ROWS    = 8,
  parameter int PLANE_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [PLANE_W-1:0]            plane_i,
  input  logic [COLS*ROWS-1:0]          rho_i,
  input  logic [COLS*ROWS-1:0]          tau_i,
  input  logic [COLS*ROWS-1:0]          delta_i,
  input  logic [COLS*ROWS-1:0]          bit_i,
  input  logic [COLS*ROWS*PLANE_W-1:0]  first_nz_i,
  output logic [COLS*ROWS-1:0]          spp_o,
  output logic [COLS*ROWS-1:0]          mrp_o,
  output logic [COLS*ROWS-1:0]          cup_o,
  output logic [COLS*ROWS-1:0]          zc_o,
  output logic [COLS*ROWS-1:0]          rlc_o,
  output logic [COLS*ROWS-1:0]          mrc_o,
  output logic [COLS*ROWS-1:0]          sc_o,
  output logic [COLS*ROWS-1:0]          again_o,
  output logic [COLS*ROWS-1:0]          sig_o,
  output logic [NUM_PHASES-1:0]         phase_o
);
  localparam int N = COLS * ROWS;

  logic [N-1:0] spp_c, mrp_c, cup_c, sig_c, again_c, rlc_c;
  logic [N-1:0] zc_c, sc_c;
  logic         accept;

  logic [N-1:0] spp_q, mrp_q, cup_q, zc_q, rlc_q, mrc_q, sc_q, again_q, sig_q;
  logic [N-1:0] spp_d, mrp_d, cup_d, zc_d, rlc_d, mrc_d, sc_d, again_d, sig_d;
  logic         valid_q, valid_d;

  bitplane_pass_split #(.NBITS(N), .PLANE_W(PLANE_W)) u_split (
    .rho_i      (rho_i),
    .tau_i      (tau_i),
    .delta_i    (delta_i),
    .first_nz_i (first_nz_i),
    .plane_i    (plane_i),
    .spp_o      (spp_c),
    .mrp_o      (mrp_c),
    .cup_o      (cup_c),
    .sig_o      (sig_c),
    .again_o    (again_c)
  );

  bitplane_run_finder #(.COLS(COLS), .ROWS(ROWS)) u_run (
    .cup_i (cup_c),
    .bit_i (bit_i),
    .sig_i (sig_c),
    .rlc_o (rlc_c)
  );

  bitplane_phase_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .phase_o  (phase_o)
  );

  assign zc_c = spp_c | (cup_c & ~rlc_c);
  assign sc_c = (spp_c | cup_c) & bit_i;

  always_comb begin
    spp_d = spp_q;  mrp_d = mrp_q;  cup_d = cup_q;
    zc_d  = zc_q;   rlc_d = rlc_q;  mrc_d = mrc_q;
    sc_d  = sc_q;   again_d = again_q; sig_d = sig_q;
    valid_d = valid_q;
    if (accept) begin
      spp_d = spp_c;  mrp_d = mrp_c;  cup_d = cup_c;
      zc_d  = zc_c;   rlc_d = rlc_c;  mrc_d = mrp_c;
      sc_d  = sc_c;   again_d = again_c; sig_d = sig_c;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spp_q <= '0; mrp_q <= '0; cup_q <= '0;
      zc_q  <= '0; rlc_q <= '0; mrc_q <= '0;
      sc_q  <= '0; again_q <= '0; sig_q <= '0;
      valid_q <= 1'b0;
    end else begin
      spp_q <= spp_d; mrp_q <= mrp_d; cup_q <= cup_d;
      zc_q  <= zc_d;  rlc_q <= rlc_d; mrc_q <= mrc_d;
      sc_q  <= sc_d;  again_q <= again_d; sig_q <= sig_d;
      valid_q <= valid_d;
    end
  end

  assign spp_o = spp_q;  assign mrp_o = mrp_q;  assign cup_o = cup_q;
  assign zc_o  = zc_q;   assign rlc_o = rlc_q;  assign mrc_o = mrc_q;
  assign sc_o  = sc_q;   assign again_o = again_q; assign sig_o = sig_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R1
    pass_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> $countones({spp_q[i], mrp_q[i], cup_q[i]}) == 1);
  end

  // R6
  rlc_in_cup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rlc_q & ~cup_q) == '0);
  // R6
  rlc_zc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rlc_q & zc_q) == '0);
  // R3
  mrc_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrc_q & (zc_q | rlc_q | sc_q)) == '0);
  // R3
  again_in_mrp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (again_q & ~mrp_q) == '0);
  // R9
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o != 4'b0000 |=> ($stable(spp_q) && $stable(cup_q) && $stable(rlc_q)
                            && $stable(sig_q)));
endmodule

// File: tb/bitplane_pass_sorter_test.sv
module bitplane_pass_sorter_test;
  localparam int PERIOD  = 10;
  localparam int COLS    = 4;
  localparam int ROWS    = 8;
  localparam int PLANE_W = 3;
  localparam int N       = COLS * ROWS;
  localparam int PLANES  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [PLANE_W-1:0] plane_i = '0;
  logic [N-1:0] rho_i = '0, tau_i = '0, delta_i = '0, bit_i = '0;
  logic [N*PLANE_W-1:0] first_nz_i = '0;
  logic [N-1:0] spp_o, mrp_o, cup_o, zc_o, rlc_o, mrc_o, sc_o, again_o, sig_o;
  logic [3:0] phase_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bitplane_pass_sorter #(.COLS(COLS), .ROWS(ROWS), .PLANE_W(PLANE_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .plane_i(plane_i),
    .rho_i(rho_i), .tau_i(tau_i), .delta_i(delta_i), .bit_i(bit_i),
    .first_nz_i(first_nz_i),
    .spp_o(spp_o), .mrp_o(mrp_o), .cup_o(cup_o), .zc_o(zc_o), .rlc_o(rlc_o),
    .mrc_o(mrc_o), .sc_o(sc_o), .again_o(again_o), .sig_o(sig_o),
    .phase_o(phase_o)
  );

  always #(PERIOD/2) clk = ~clk;

  // serial reference state
  int mag[N];
  bit sigma[N], eta[N], refd[N];
  logic [N-1:0] e_spp, e_mrp, e_cup, e_zc, e_rlc, e_mrc, e_sc, e_again, e_sig;
  logic [N-1:0] in_rho, in_tau, in_delta, in_bit;
  logic [N*PLANE_W-1:0] in_first;

  task automatic check(input string req, input string what,
                       input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  function automatic bit nbr_sig(int x, int y);
    for (int dy = -1; dy <= 1; dy++)
      for (int dx = -1; dx <= 1; dx++)
        if (!(dx == 0 && dy == 0) && x+dx >= 0 && x+dx < COLS &&
            y+dy >= 0 && y+dy < ROWS && sigma[(y+dy)*COLS + x+dx])
          return 1'b1;
    return 1'b0;
  endfunction

  function automatic int top_bit(int m);
    int t = 0;
    for (int b = 0; b < PLANES; b++) if ((m >> b) & 1) t = b;
    return t;
  endfunction

  // run one plane of the serial stripe scan, building inputs and expectations
  task automatic serial_plane(input int p);
    e_spp = '0; e_mrp = '0; e_cup = '0; e_zc = '0; e_rlc = '0;
    e_mrc = '0; e_sc = '0; e_again = '0; in_tau = '0; in_first = '0;
    for (int i = 0; i < N; i++) begin
      in_rho[i] = ((mag[i] >> (p+1)) != 0);
      in_bit[i] = (mag[i] >> p) & 1;
      in_first[i*PLANE_W +: PLANE_W] = PLANE_W'(top_bit(mag[i]));
      sigma[i] = in_rho[i];
      eta[i] = 1'b0;
    end
    // first pass
    for (int k = 0; k < ROWS/4; k++)
      for (int x = 0; x < COLS; x++)
        for (int r = 0; r < 4; r++) begin
          int i = (4*k + r)*COLS + x;
          if (!sigma[i] && nbr_sig(x, 4*k + r)) begin
            e_spp[i] = 1'b1; eta[i] = 1'b1; e_zc[i] = 1'b1;
            if (in_bit[i]) begin
              sigma[i] = 1'b1; in_tau[i] = 1'b1; e_sc[i] = 1'b1;
            end
          end
        end
    // refinement pass
    for (int i = 0; i < N; i++)
      if (sigma[i] && !eta[i]) begin
        e_mrp[i] = 1'b1; e_mrc[i] = 1'b1; e_again[i] = refd[i]; refd[i] = 1'b1;
      end
    // cleanup pass
    for (int k = 0; k < ROWS/4; k++)
      for (int x = 0; x < COLS; x++) begin
        bit run = 1'b1;
        for (int r = 0; r < 4; r++) begin
          int i = (4*k + r)*COLS + x;
          if (sigma[i] || eta[i] || nbr_sig(x, 4*k + r)) run = 1'b0;
        end
        if (run) begin
          bit found = 1'b0;
          for (int r = 0; r < 4; r++) begin
            int i = (4*k + r)*COLS + x;
            e_cup[i] = 1'b1;
            if (!found) e_rlc[i] = 1'b1;
            else        e_zc[i] = 1'b1;
            if (in_bit[i]) begin
              found = 1'b1; e_sc[i] = 1'b1; sigma[i] = 1'b1;
            end
          end
        end else begin
          for (int r = 0; r < 4; r++) begin
            int i = (4*k + r)*COLS + x;
            if (!sigma[i] && !eta[i]) begin
              e_cup[i] = 1'b1; e_zc[i] = 1'b1;
              if (in_bit[i]) begin e_sc[i] = 1'b1; sigma[i] = 1'b1; end
            end
          end
        end
      end
    in_delta = e_spp;
    e_sig = in_rho | in_tau;
  endtask

  task automatic drive_and_start(input int p);
    @(negedge clk);
    plane_i = PLANE_W'(p);
    rho_i = in_rho; tau_i = in_tau; delta_i = in_delta; bit_i = in_bit;
    first_nz_i = in_first;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic compare_all();
    check("R1", "spp", spp_o, e_spp);
    check("R1", "mrp", mrp_o, e_mrp);
    check("R1", "cup", cup_o, e_cup);
    check("R2_R4_R6", "zc", zc_o, e_zc);
    check("R5_R6", "rlc", rlc_o, e_rlc);
    check("R3", "mrc", mrc_o, e_mrc);
    check("R2_R4_R6", "sc", sc_o, e_sc);
    check("R3", "again", again_o, e_again);
    check("R7", "sig", sig_o, e_sig);
  endtask

  task automatic run_image();
    for (int i = 0; i < N; i++) refd[i] = 1'b0;
    for (int p = PLANES-1; p >= 0; p--) begin
      serial_plane(p);
      drive_and_start(p);
      compare_all();
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    #(PERIOD*200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] hold_spp, hold_cup, hold_rlc, hold_sig;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", "spp reset", spp_o, '0);
    check("R10", "rlc reset", rlc_o, '0);
    check("R10", "sig reset", sig_o, '0);
    check("R10", "phase reset", {{(N-4){1'b0}}, phase_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 phase order, on an all-zero image (every column a run column, R5)
    for (int i = 0; i < N; i++) mag[i] = 0;
    for (int i = 0; i < N; i++) refd[i] = 1'b0;
    serial_plane(3);
    drive_and_start(3);
    check("R8", "phase mrc", {{(N-4){1'b0}}, phase_o}, N'(4'b0001));
    compare_all();
    hold_spp = spp_o; hold_cup = cup_o; hold_rlc = rlc_o; hold_sig = sig_o;
    @(negedge clk);
    check("R8", "phase rlc", {{(N-4){1'b0}}, phase_o}, N'(4'b0010));
    // R9 start while busy, with different inputs
    rho_i = '1; tau_i = '0; delta_i = '0; bit_i = '1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R8", "phase zc", {{(N-4){1'b0}}, phase_o}, N'(4'b0100));
    check("R9", "spp held", spp_o, hold_spp);
    check("R9", "cup held", cup_o, hold_cup);
    check("R9", "rlc held", rlc_o, hold_rlc);
    check("R9", "sig held", sig_o, hold_sig);
    @(negedge clk);
    check("R8", "phase sc", {{(N-4){1'b0}}, phase_o}, N'(4'b1000));
    @(negedge clk);
    check("R8", "phase idle", {{(N-4){1'b0}}, phase_o}, '0);
    check("R9", "rlc still held", rlc_o, hold_rlc);

    // directed images: full, single coefficients on stripe edges
    for (int i = 0; i < N; i++) mag[i] = 15;
    run_image();
    for (int pos = 0; pos < N; pos++) begin
      for (int i = 0; i < N; i++) mag[i] = 0;
      mag[pos] = 8 + (pos % 8);
      run_image();
    end
    // random images of varying density
    for (int img = 0; img < 300; img++) begin
      int dens = 1 + (img % 6);
      for (int i = 0; i < N; i++)
        mag[i] = (($urandom % 8) < dens) ? int'($urandom % 16) : 0;
      run_image();
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule